// File: doc/BRIEF.md
# Dual-Edge Word Serializer

The block turns a parallel word of even width into one serial bit stream that carries a bit in every half-period of the bit clock. The word is split into two lanes. The even-indexed bits go to a shift row clocked on the rising edge. The odd-indexed bits go to a second row clocked on the falling edge. A selector driven by the clock level joins the two rows at the output. No binary mux tree is involved, so the ratio can be any even number, and 20 or 6 work as well as 8 or 16.

Each row holds half the word, so a full word leaves in WIDTH/2 bit-clock cycles. The block asks for data with a one-cycle request pulse at the end of each word period. The upstream logic answers by presenting a word together with a load strobe in that same cycle. When no word is loaded, the rows fill with zeros and the line stays low.

Top module: `ddr_serializer`

## Requirements
- R1: The WIDTH parameter may be any even value of at least 4, and every bit of a loaded word is sent exactly once. The default is 20. The block is also used at 6.
- R2: `word_req` is high for exactly one bit-clock cycle and low for the other WIDTH/2-1 cycles of every word period, so consecutive pulses are WIDTH/2 cycles apart.
- R3: A word presented with `load` high during a `word_req` cycle is captured at the rising edge that ends that cycle. Word bit 2k is then on `serial_out` during the high phase of the k-th cycle after that edge, counting from 0. Bit 2k+1 is on `serial_out` during the low phase of the same cycle. Bit 0 goes first and the bits follow in ascending index order.
- R4: Words loaded at consecutive requests leave with no gap. Bit 0 of the next word directly follows the last bit of the previous word.
- R5: If no word is loaded at a request, `serial_out` is low for every half-period of the following word period.
- R6: A `load` strobe outside a `word_req` cycle has no effect on `serial_out`.
- R7: While `rst_n` is low, `serial_out` and `word_req` are low. Reset asserts asynchronously and is released on a rising edge. After release, `serial_out` stays low until the first loaded word starts.
- R8: During high clock phases `serial_out` carries only even-indexed word bits, from the rising-edge row. During low phases it carries only odd-indexed bits, from the falling-edge row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock. Both edges move data. |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously inside the block. |
| word_in | input | WIDTH | Parallel word. Bit 0 is sent first. |
| load | input | 1 | Word strobe. It is taken only in a `word_req` cycle. |
| serial_out | output | 1 | Serial stream, one bit per clock half-period. |
| word_req | output | 1 | One-cycle pulse that marks the cycle in which the next word may be offered. |

## Verification
On every cycle, the assertions check four things: the one-cycle width of the request pulse, that a captured word lands in both rows, that zeros enter a row whenever it shifts, and that the output is quiet in reset. Only the bench's scenarios can show that the stream rebuilt from both clock phases matches the loaded words in order and with no gap. The same holds for idle periods producing a low line and for stray strobes between requests being dropped. The bench covers this exhaustively over every word value at width 6, and with walking-one and mixed patterns at width 20.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;
endpackage

// File: rtl/dser_word_timer.sv
module dser_word_timer #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic last
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv;

  assign adv = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (adv) cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == TOP);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
endmodule

// File: rtl/dser_shift_row.sv
module dser_shift_row import ddr_ser_pkg::*; #(
  parameter int    HALF = 10,
  parameter edge_e EDGE = EDGE_RISE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [HALF-1:0] load_bits,
  output logic            head
);
  logic [HALF-1:0] row_q, row_d;

  always_comb begin
    if (load) row_d = load_bits;
    else      row_d = {1'b0, row_q[HALF-1:1]};
  end

  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
      end

      a_r5_rise_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (row_q[HALF-1] == 1'b0));

      a_r3_rise_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (row_q == $past(load_bits)));
    end else begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
      end

      a_r5_fall_zero_fill: assert property (@(negedge clk) disable iff (!rst_n)
        !load |=> (row_q[HALF-1] == 1'b0));

      a_r8_fall_capture: assert property (@(negedge clk) disable iff (!rst_n)
        load |=> (row_q == $past(load_bits)));
    end
  endgenerate

  assign head = row_q[0];
endmodule

// File: rtl/dser_edge_mux.sv
module dser_edge_mux (
  input  logic clk,
  input  logic en,
  input  logic rise_bit,
  input  logic fall_bit,
  output logic dout
);
  always_comb begin
    if (!en)     dout = 1'b0;
    else if (clk) dout = rise_bit;
    else          dout = fall_bit;
  end
endmodule

// File: rtl/ddr_serializer.sv
module ddr_serializer import ddr_ser_pkg::*; #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] word_in,
  input  logic             load,
  output logic             serial_out,
  output logic             word_req
);
  localparam int HALF = WIDTH / 2;

  // reset: asynchronous assertion, release on a rising edge
  logic [1:0] rsync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ok = rsync_q[1];

  // word period timing
  logic period_end;
  logic take;

  dser_word_timer #(.HALF(HALF)) u_timer (
    .clk   (clk),
    .rst_n (rst_ok),
    .last  (period_end)
  );

  assign word_req = period_end;
  assign take     = load & period_end;

  // lane split: even bits to the rising row, odd bits to the falling row
  logic [HALF-1:0] even_bits, odd_bits;

  generate
    for (genvar i = 0; i < HALF; i++) begin : g_lane
      assign even_bits[i] = word_in[2*i];
      assign odd_bits[i]  = word_in[2*i+1];
    end
  endgenerate

  // odd lane is held across the half cycle up to the falling edge
  logic [HALF-1:0] odd_hold_q, odd_hold_d;
  logic            hold_vld_q, hold_vld_d;

  always_comb begin
    odd_hold_d = odd_hold_q;
    if (take) odd_hold_d = odd_bits;
    hold_vld_d = take;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      odd_hold_q <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      odd_hold_q <= odd_hold_d;
      hold_vld_q <= hold_vld_d;
    end
  end

  logic rise_head, fall_head;

  dser_shift_row #(.HALF(HALF), .EDGE(EDGE_RISE)) u_row_rise (
    .clk       (clk),
    .rst_n     (rst_ok),
    .load      (take),
    .load_bits (even_bits),
    .head      (rise_head)
  );

  dser_shift_row #(.HALF(HALF), .EDGE(EDGE_FALL)) u_row_fall (
    .clk       (clk),
    .rst_n     (rst_ok),
    .load      (hold_vld_q),
    .load_bits (odd_hold_q),
    .head      (fall_head)
  );

  dser_edge_mux u_mux (
    .clk      (clk),
    .en       (rst_ok),
    .rise_bit (rise_head),
    .fall_bit (fall_head),
    .dout     (serial_out)
  );

  a_r3_first_bit: assert property (@(posedge clk) disable iff (!rst_ok)
    take |=> (rise_head == $past(word_in[0])));

  a_r4_hold_single: assert property (@(posedge clk) disable iff (!rst_ok)
    hold_vld_q |=> !hold_vld_q);

  a_r7_quiet_in_reset: assert property (@(negedge clk)
    !rst_n |-> (serial_out == 1'b0 && word_req == 1'b0));
endmodule

// File: tb/ddr_serializer_test.sv
module dser_lane_check #(
  parameter int W = 20
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_fail,
  output logic done
);
  localparam int H  = W / 2;
  localparam int NW = (W <= 8) ? (1 << W) : W + 4;

  logic [W-1:0] word_in;
  logic         load;
  logic         serial_out;
  logic         word_req;

  ddr_serializer #(.WIDTH(W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_in    (word_in),
    .load       (load),
    .serial_out (serial_out),
    .word_req   (word_req)
  );

  function automatic logic [W-1:0] even_mask();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i % 2 == 0);
    return m;
  endfunction

  function automatic logic [W-1:0] pat(int k);
    logic [W-1:0] v;
    if (W <= 8)      v = W'(k);
    else if (k < W)  v = W'(1) << k;
    else if (k == W) v = '1;
    else begin
      for (int i = 0; i < W; i++) v[i] = ((i % 2) == 1);
      if (k == W + 2) v = ~v;
      if (k == W + 3) v = W'(32'h9E3779B1 * 32'(k + 1));
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (W=%0d) actual=%h expected=%h", req, W, act, exp);
    end
  endtask

  // Collects one word period starting right after a boundary edge.
  task automatic slot(input logic [W-1:0] exp, input logic nl,
                      input logic [W-1:0] nd, input bit stray, input string tag);
    logic [W-1:0] rx;
    rx = '0;
    for (int c = 0; c < H; c++) begin
      @(posedge clk); #1;
      rx[2*c] = serial_out;
      if (c == 0) load = 1'b0;
      if (stray && c == 1) begin load = 1'b1; word_in = '1; end
      if (stray && c == 2) load = 1'b0;
      if (c == H - 1) begin
        chk(word_req == 1'b1, "R2 request in last cycle", W'(word_req), W'(1));
        load    = nl;
        word_in = nd;
      end else begin
        chk(word_req == 1'b0, "R2 no request mid-word", W'(word_req), W'(0));
      end
      @(negedge clk); #1;
      rx[2*c+1] = serial_out;
    end
    chk(rx == exp, tag, rx, exp);
    chk((rx & even_mask()) == (exp & even_mask()), "R8 high phases carry even bits",
        rx & even_mask(), exp & even_mask());
  endtask

  initial begin
    n_chk   = 0;
    n_fail  = 0;
    done    = 1'b0;
    load    = 1'b1;
    word_in = '1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(serial_out == 1'b0, "R7 serial low in reset", W'(serial_out), W'(0));
      chk(word_req == 1'b0, "R7 request low in reset", W'(word_req), W'(0));
      @(negedge clk); #1;
      chk(serial_out == 1'b0, "R7 serial low in reset", W'(serial_out), W'(0));
    end
    load    = 1'b0;
    word_in = '0;
    wait (rst_n == 1'b1);
    do begin
      @(posedge clk); #1;
      chk(serial_out == 1'b0, "R7 low until first word", W'(serial_out), W'(0));
    end while (word_req != 1'b1);
    load    = 1'b1;
    word_in = pat(0);
    for (int k = 0; k < NW; k++) begin
      slot(pat(k), (k + 1 < NW), (k + 1 < NW) ? pat(k + 1) : '0, 1'b0,
           (k == 0) ? "R1/R3 first word rebuilt" : "R1/R4 back-to-back word rebuilt");
    end
    slot('0, 1'b0, '0, 1'b1, "R5 unloaded period stays low");
    slot('0, 1'b0, '0, 1'b0, "R6 stray strobe ignored");
    done = 1'b1;
  end
endmodule

module ddr_serializer_test;
  logic clk = 1'b0;
  logic rst_n;
  int   c20, f20, c6, f6;
  logic d20, d6;

  always #2 clk = ~clk;

  dser_lane_check #(.W(20)) lane20 (
    .clk(clk), .rst_n(rst_n), .n_chk(c20), .n_fail(f20), .done(d20));

  dser_lane_check #(.W(6)) lane6 (
    .clk(clk), .rst_n(rst_n), .n_chk(c6), .n_fail(f6), .done(d6));

  initial begin
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
  end

  initial begin
    int  cyc;
    bit  hung;
    int  checks;
    int  fails;
    cyc = 0;
    while (!(d20 === 1'b1 && d6 === 1'b1) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    #3;
    hung   = !(d20 === 1'b1 && d6 === 1'b1);
    checks = c20 + c6 + 1;
    fails  = f20 + f6;
    if (hung) begin
      fails++;
      $display("FAIL watchdog R2 run did not finish: actual=%0d cycles expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule